// File: doc/BRIEF.md
# Parallel Nonce Search Coordinator

This block runs a proof-of-work search across a parameterised array of hash units. The hash permutation is outside the block. Each unit reaches its own permutation engine through a start/done handshake that carries a full ternary state. Trits are packed two bits each. Trit i sits in bits [2i+1:2i], and the codes are 00 = 0, 01 = +1 and 11 = -1. Code 10 is illegal.

A job begins with a start pulse and a host seed. Unit 0 acts as the master. It absorbs the nonce-free message, one rate-sized chunk at a time, into a shared midstate. Each chunk is XOR-ed into the rate trits and then permuted on unit 0's engine. After the last chunk, every unit loads the midstate with its own nonce written into the low trits. Each unit permutes that state and tests the low end of the hash for the required run of zero trits. A unit that misses steps its nonce generator and tries again.

The first success ends the search in every unit. The winning nonce and unit index are reported on a one-cycle write-out strobe, and an interrupt pulse follows in the next cycle. The required zero count comes from a host-writable register. An abort input drops the job without any result.

Top module: `nonce_search_coord`

## Requirements
- R1: A hash passes when its trits 0 through D-1 all carry code 00, where D is the job's difficulty. Codes 01 and 11 in that range fail the test. D = 0 passes any hash.
- R2: On each start the midstate is cleared. Each accepted chunk is XOR-ed into trits 0..RATE_TRITS-1 of the midstate and permuted on unit 0, and the permuted result becomes the new midstate. msg_ready is high only during absorb while no absorb permutation is outstanding.
- R3: The first search state that unit u sends to its engine equals the final midstate with trits 0..NONCE_W-1 replaced by nonce bits. A bit of 1 becomes code 01 and a bit of 0 becomes code 00.
- R4: Unit u starts from job_seed XOR salt(u), where salt(u) = ((u+1)*0x5A3) mod 2^NONCE_W. A zero result is replaced by 1. After each failing hash the nonce steps once: shift right by one, then XOR with 0xE08 if the bit shifted out was 1.
- R5: When one or more units pass in the same cycle, the lowest index wins. wr_valid pulses for exactly one cycle, carrying wr_nonce (the nonce that produced the passing hash) and wr_unit.
- R6: From the cycle after a winning hash is seen, no unit issues another permutation start.
- R7: irq pulses for one cycle, in the cycle right after wr_valid.
- R8: The difficulty register is written through cfg_diff_we and sampled at job start. Writes made during a job do not affect that job.
- R9: After reset, busy, done, wr_valid, irq, msg_ready and every perm_start are low. busy is high from an accepted start until a result or an abort. done rises together with wr_valid and stays high until the next start.
- R10: job_abort during absorb or search returns the block to idle, with busy and done low and no write-out or interrupt. A later start runs a normal job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_diff_we | input | 1 | Write strobe for the difficulty register |
| cfg_diff_wdata | input | DW | Required count of trailing zero trits |
| job_start | input | 1 | Starts a job when idle or done and no permutation is outstanding |
| job_seed | input | NONCE_W | Host seed mixed into every unit's first nonce |
| job_abort | input | 1 | Cancels the running job |
| msg_valid | input | 1 | Message chunk present |
| msg_ready | output | 1 | Chunk accepted this cycle when valid |
| msg_chunk | input | 2*RATE_TRITS | One rate-sized chunk of trits |
| msg_last | input | 1 | Marks the final chunk |
| perm_start | output | N_UNITS | Per-engine start pulse |
| perm_din | output | N_UNITS*2*STATE_TRITS | Per-engine input state |
| perm_done | input | N_UNITS | Per-engine completion pulse |
| perm_dout | input | N_UNITS*2*STATE_TRITS | Per-engine permuted state |
| busy | output | 1 | Job in progress |
| done | output | 1 | Result delivered |
| wr_valid | output | 1 | Write-out strobe |
| wr_nonce | output | NONCE_W | Winning nonce |
| wr_unit | output | UW | Index of the winning unit |
| irq | output | 1 | Interrupt pulse toward the host |

## Verification
A table of seeds, difficulties, chunk counts and message bases drives whole jobs. The stand-in engine rotates the state by one trit, so the passing condition depends on both the midstate and the nonce. The bench predicts every unit's iteration count from its own nonce generator model. Different seeds and difficulties therefore separate correct seed salting, nonce stepping and lowest-index selection from near misses, and the captured first search states separate correct absorb chaining from a stale or mis-ordered midstate.

Directed jobs cover three more cases. Difficulty zero makes every unit pass at once, which isolates the tie rule. A difficulty rewrite in mid-job shows whether the value was sampled at start. A job that cannot succeed is aborted to show that no write-out or interrupt leaks out.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_ABSORB = 2'd1,
    CS_SEARCH = 2'd2,
    CS_DONE   = 2'd3
  } coord_state_t;

  // Trit code for zero; the difficulty test only accepts this code.
  localparam logic [1:0] TRIT_ZERO = 2'b00;
endpackage

// File: rtl/nsc_absorb.sv
module nsc_absorb #(
  parameter int SW = 48,
  parameter int RW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          chunk_fire,
  input  logic [RW-1:0] chunk,
  input  logic          chunk_last,
  input  logic          perm_done,
  input  logic [SW-1:0] perm_dout,
  output logic [SW-1:0] midstate,
  output logic          perm_start,
  output logic [SW-1:0] perm_din,
  output logic          perm_busy,
  output logic          absorb_fin
);
  logic [SW-1:0] mid_q, din_q;
  logic          start_q, busy_q, last_q;

  // Sponge step: XOR the chunk into the rate trits at the low end.
  function automatic logic [SW-1:0] mix_chunk(input logic [SW-1:0] m, input logic [RW-1:0] c);
    return m ^ {{(SW-RW){1'b0}}, c};
  endfunction

  assign absorb_fin = perm_done && busy_q && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q   <= '0;
      din_q   <= '0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (clear) begin
        mid_q  <= '0;
        last_q <= 1'b0;
      end
      if (chunk_fire) begin
        din_q   <= mix_chunk(mid_q, chunk);
        start_q <= 1'b1;
        busy_q  <= 1'b1;
        last_q  <= chunk_last;
      end
      if (perm_done && busy_q) begin
        busy_q <= 1'b0;
        mid_q  <= perm_dout;
      end
    end
  end

  assign midstate   = mid_q;
  assign perm_start = start_q;
  assign perm_din   = din_q;
  assign perm_busy  = busy_q || start_q;

  assert_no_chunk_while_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_fire |-> !busy_q);
endmodule

// File: rtl/nsc_unit.sv
module nsc_unit #(
  parameter int          STATE_TRITS = 24,
  parameter int          NONCE_W     = 12,
  parameter int          DW          = 5,
  parameter logic [NONCE_W-1:0] TAPS = 12'hE08,
  localparam int         SW          = 2 * STATE_TRITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [NONCE_W-1:0] seed,
  input  logic               stop,
  input  logic [SW-1:0]      midstate,
  input  logic [DW-1:0]      diff,
  input  logic               perm_done,
  input  logic [SW-1:0]      perm_dout,
  output logic               perm_start,
  output logic [SW-1:0]      perm_din,
  output logic               hit,
  output logic [NONCE_W-1:0] nonce,
  output logic               pending
);
  import nsc_pkg::*;

  logic [NONCE_W-1:0] nonce_q;
  logic               issue_q, pend_q;
  logic               tail_ok;

  function automatic logic [NONCE_W-1:0] lfsr_next(input logic [NONCE_W-1:0] n);
    return n[0] ? ((n >> 1) ^ TAPS) : (n >> 1);
  endfunction

  // Nonce bits become trits 0..NONCE_W-1 (1 -> +1, 0 -> 0).
  function automatic logic [SW-1:0] load_nonce(input logic [SW-1:0] m, input logic [NONCE_W-1:0] n);
    logic [SW-1:0] s;
    s = m;
    for (int i = 0; i < NONCE_W; i++) s[2*i +: 2] = {1'b0, n[i]};
    return s;
  endfunction

  function automatic logic tail_clear(input logic [SW-1:0] h, input logic [DW-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < STATE_TRITS; i++)
      if (i < int'(d) && h[2*i +: 2] != TRIT_ZERO) ok = 1'b0;
    return ok;
  endfunction

  assign tail_ok    = tail_clear(perm_dout, diff);
  assign perm_start = issue_q && !stop;
  assign perm_din   = load_nonce(midstate, nonce_q);
  assign hit        = perm_done && pend_q && !stop && tail_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nonce_q <= '0;
      issue_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (go) begin
      nonce_q <= seed;
      issue_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (perm_start) begin
        issue_q <= 1'b0;
        pend_q  <= 1'b1;
      end
      if (perm_done && pend_q) begin
        pend_q <= 1'b0;
        if (!tail_ok && !stop) begin
          nonce_q <= lfsr_next(nonce_q);
          issue_q <= 1'b1;
        end
      end
      if (stop) issue_q <= 1'b0;
    end
  end

  assign nonce   = nonce_q;
  assign pending = pend_q || issue_q;

  assert_issue_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    perm_start |-> !pend_q);
endmodule

// File: rtl/nsc_pick.sv
module nsc_pick #(
  parameter int N  = 3,
  parameter int UW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [UW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = UW'(i);
      end
    end
  end

  assert_pick_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> hits[idx]);
endmodule

// File: rtl/nonce_search_coord.sv
module nonce_search_coord #(
  parameter int                 N_UNITS     = 3,
  parameter int                 STATE_TRITS = 24,
  parameter int                 RATE_TRITS  = 12,
  parameter int                 NONCE_W     = 12,
  parameter logic [NONCE_W-1:0] LFSR_TAPS   = 12'hE08,
  parameter logic [NONCE_W-1:0] SEED_SALT   = 12'h5A3,
  localparam int SW = 2 * STATE_TRITS,
  localparam int RW = 2 * RATE_TRITS,
  localparam int DW = $clog2(STATE_TRITS + 1),
  localparam int UW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_diff_we,
  input  logic [DW-1:0]         cfg_diff_wdata,
  input  logic                  job_start,
  input  logic [NONCE_W-1:0]    job_seed,
  input  logic                  job_abort,
  input  logic                  msg_valid,
  output logic                  msg_ready,
  input  logic [RW-1:0]         msg_chunk,
  input  logic                  msg_last,
  output logic [N_UNITS-1:0]    perm_start,
  output logic [N_UNITS*SW-1:0] perm_din,
  input  logic [N_UNITS-1:0]    perm_done,
  input  logic [N_UNITS*SW-1:0] perm_dout,
  output logic                  busy,
  output logic                  done,
  output logic                  wr_valid,
  output logic [NONCE_W-1:0]    wr_nonce,
  output logic [UW-1:0]         wr_unit,
  output logic                  irq
);
  import nsc_pkg::*;

  coord_state_t       state_q;
  logic [DW-1:0]      diff_reg, job_diff;
  logic [NONCE_W-1:0] seed_q;
  logic               wr_valid_q, irq_q;
  logic [NONCE_W-1:0] wr_nonce_q;
  logic [UW-1:0]      wr_unit_q;

  logic [SW-1:0]      midstate, abs_din;
  logic               abs_start, abs_busy, absorb_fin;
  logic               chunk_fire, start_ok, unit_go, unit_stop, drained;
  logic               any_hit, found_evt;
  logic [UW-1:0]      win_idx;
  logic [N_UNITS-1:0] unit_hit, unit_pend, unit_start;
  logic [NONCE_W-1:0] unit_nonce [N_UNITS];
  logic [SW-1:0]      unit_din   [N_UNITS];

  function automatic logic [NONCE_W-1:0] unit_seed(input logic [NONCE_W-1:0] host, input int u);
    logic [NONCE_W-1:0] salt, s;
    salt = NONCE_W'((u + 1) * int'(SEED_SALT));
    s    = host ^ salt;
    if (s == '0) s = {{(NONCE_W-1){1'b0}}, 1'b1};
    return s;
  endfunction

  assign drained    = !abs_busy && (unit_pend == '0);
  assign start_ok   = job_start && drained && (state_q == CS_IDLE || state_q == CS_DONE);
  assign msg_ready  = (state_q == CS_ABSORB) && !abs_busy;
  assign chunk_fire = msg_valid && msg_ready && !job_abort;
  assign unit_go    = (state_q == CS_ABSORB) && absorb_fin && !job_abort;
  assign unit_stop  = (state_q != CS_SEARCH);
  assign found_evt  = (state_q == CS_SEARCH) && any_hit && !job_abort;

  nsc_absorb #(.SW(SW), .RW(RW)) u_absorb (
    .clk(clk), .rst_n(rst_n), .clear(start_ok),
    .chunk_fire(chunk_fire), .chunk(msg_chunk), .chunk_last(msg_last),
    .perm_done(perm_done[0]), .perm_dout(perm_dout[SW-1:0]),
    .midstate(midstate), .perm_start(abs_start), .perm_din(abs_din),
    .perm_busy(abs_busy), .absorb_fin(absorb_fin)
  );

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    nsc_unit #(.STATE_TRITS(STATE_TRITS), .NONCE_W(NONCE_W), .DW(DW), .TAPS(LFSR_TAPS)) u_unit (
      .clk(clk), .rst_n(rst_n), .go(unit_go), .seed(unit_seed(seed_q, g)),
      .stop(unit_stop), .midstate(midstate), .diff(job_diff),
      .perm_done(perm_done[g]), .perm_dout(perm_dout[g*SW +: SW]),
      .perm_start(unit_start[g]), .perm_din(unit_din[g]),
      .hit(unit_hit[g]), .nonce(unit_nonce[g]), .pending(unit_pend[g])
    );
    if (g == 0) begin : g_master
      assign perm_start[0]   = unit_start[0] || abs_start;
      assign perm_din[SW-1:0] = abs_start ? abs_din : unit_din[0];
    end else begin : g_slave
      assign perm_start[g]        = unit_start[g];
      assign perm_din[g*SW +: SW] = unit_din[g];
    end
  end

  nsc_pick #(.N(N_UNITS), .UW(UW)) u_pick (
    .clk(clk), .rst_n(rst_n), .hits(unit_hit), .any(any_hit), .idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      diff_reg   <= '0;
      job_diff   <= '0;
      seed_q     <= '0;
      wr_valid_q <= 1'b0;
      wr_nonce_q <= '0;
      wr_unit_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      irq_q      <= wr_valid_q;
      if (cfg_diff_we) diff_reg <= cfg_diff_wdata;
      unique case (state_q)
        CS_IDLE, CS_DONE: if (start_ok) begin
          state_q  <= CS_ABSORB;
          job_diff <= diff_reg;
          seed_q   <= job_seed;
        end
        CS_ABSORB: begin
          if (job_abort)       state_q <= CS_IDLE;
          else if (absorb_fin) state_q <= CS_SEARCH;
        end
        CS_SEARCH: begin
          if (job_abort) state_q <= CS_IDLE;
          else if (any_hit) begin
            state_q    <= CS_DONE;
            wr_valid_q <= 1'b1;
            wr_nonce_q <= unit_nonce[win_idx];
            wr_unit_q  <= win_idx;
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == CS_ABSORB) || (state_q == CS_SEARCH);
  assign done     = (state_q == CS_DONE);
  assign wr_valid = wr_valid_q;
  assign wr_nonce = wr_nonce_q;
  assign wr_unit  = wr_unit_q;
  assign irq      = irq_q;

  assert_irq_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_valid));
  assert_write_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_halt_after_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    found_evt |=> (perm_start == '0));
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (job_abort && busy) |=> (!wr_valid && !done));
  assert_diff_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_SEARCH && $past(state_q == CS_SEARCH)) |-> $stable(job_diff));
  assert_done_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> wr_valid);
endmodule

// File: tb/nonce_search_coord_bench.sv
module nonce_search_coord_bench;
  localparam int NU = 3;
  localparam int ST = 24;
  localparam int NW = 12;
  localparam int SW = 2 * ST;
  localparam int RW = 24;
  localparam int DW = 5;
  localparam int UW = 2;
  localparam int LAT = 3;
  localparam int BOUND = 600;
  localparam logic [NW-1:0] TAPS = 12'hE08;
  localparam logic [NW-1:0] SALT = 12'h5A3;

  // Table: {seed, difficulty, chunk count - 1, message base}
  localparam logic [42:0] VECS [6] = '{
    {12'h3C1, 5'd2, 2'd0, 24'hA5F00F},
    {12'h7E2, 5'd3, 2'd1, 24'h0C3C33},
    {12'h015, 5'd4, 2'd2, 24'h5D7001},
    {12'hF00, 5'd1, 2'd0, 24'hFFFFFF},
    {12'h9A9, 5'd5, 2'd1, 24'h131313},
    {12'h444, 5'd3, 2'd2, 24'h00F0C1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_diff_we = 1'b0;
  logic [DW-1:0] cfg_diff_wdata = '0;
  logic job_start = 1'b0, job_abort = 1'b0;
  logic [NW-1:0] job_seed = '0;
  logic msg_valid = 1'b0, msg_last = 1'b0, msg_ready;
  logic [RW-1:0] msg_chunk = '0;
  logic [NU-1:0] perm_start, perm_done;
  logic [NU*SW-1:0] perm_din, perm_dout;
  logic busy, done, wr_valid, irq;
  logic [NW-1:0] wr_nonce;
  logic [UW-1:0] wr_unit;

  int checks = 0, fails = 0;
  int cnt [NU], start_cnt [NU], cap_idx [NU];
  logic [SW-1:0] held [NU], cap_din [NU];
  int wr_cnt = 0, irq_cnt = 0;

  always #5 clk = ~clk;

  nonce_search_coord u_nonce_search_coord (
    .clk(clk), .rst_n(rst_n), .cfg_diff_we(cfg_diff_we), .cfg_diff_wdata(cfg_diff_wdata),
    .job_start(job_start), .job_seed(job_seed), .job_abort(job_abort),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_chunk(msg_chunk), .msg_last(msg_last),
    .perm_start(perm_start), .perm_din(perm_din), .perm_done(perm_done), .perm_dout(perm_dout),
    .busy(busy), .done(done), .wr_valid(wr_valid), .wr_nonce(wr_nonce), .wr_unit(wr_unit),
    .irq(irq)
  );

  // Stand-in permutation: rotate the state up by one trit.
  function automatic logic [SW-1:0] b_perm(input logic [SW-1:0] s);
    return {s[SW-3:0], s[SW-1:SW-2]};
  endfunction

  function automatic logic [NW-1:0] b_step(input logic [NW-1:0] n);
    logic lsb = n[0];
    n = {1'b0, n[NW-1:1]};
    if (lsb) n = n ^ TAPS;
    return n;
  endfunction

  function automatic logic [NW-1:0] b_seed(input logic [NW-1:0] host, input int u);
    logic [NW-1:0] salt = '0;
    for (int k = 0; k <= u; k++) salt = salt + SALT;
    if ((host ^ salt) == '0) return 1;
    return host ^ salt;
  endfunction

  function automatic logic [SW-1:0] b_insert(input logic [SW-1:0] m, input logic [NW-1:0] n);
    for (int i = 0; i < NW; i++) begin
      m[2*i] = n[i];
      m[2*i+1] = 1'b0;
    end
    return m;
  endfunction

  function automatic bit b_pass(input logic [SW-1:0] h, input int d);
    int z = 0;
    while (z < ST && h[2*z +: 2] == 2'b00) z++;
    return z >= d;
  endfunction

  function automatic logic [RW-1:0] b_chunk(input logic [RW-1:0] base, input int k);
    return base ^ RW'(k * 24'h0F0F3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic write_diff(input int d);
    cfg_diff_we = 1'b1;
    cfg_diff_wdata = DW'(d);
    tick();
    cfg_diff_we = 1'b0;
  endtask

  // Permutation engines plus write-out/interrupt monitor, one process.
  initial begin
    perm_done = '0;
    perm_dout = '0;
    for (int u = 0; u < NU; u++) begin
      cnt[u] = 0; start_cnt[u] = 0; cap_idx[u] = -1; held[u] = '0; cap_din[u] = '0;
    end
    forever begin
      @(negedge clk);
      if (wr_valid === 1'b1) wr_cnt++;
      if (irq === 1'b1) irq_cnt++;
      for (int u = 0; u < NU; u++) begin
        perm_done[u] = 1'b0;
        if (cnt[u] > 0) begin
          cnt[u]--;
          if (cnt[u] == 0) begin
            perm_done[u] = 1'b1;
            perm_dout[u*SW +: SW] = b_perm(held[u]);
          end
        end
        if (perm_start[u] === 1'b1) begin
          held[u] = perm_din[u*SW +: SW];
          if (start_cnt[u] == cap_idx[u]) cap_din[u] = held[u];
          start_cnt[u]++;
          cnt[u] = LAT;
        end
      end
    end
  end

  task automatic run_job(input logic [NW-1:0] seed, input int d, input int nch,
                         input logic [RW-1:0] base, input bit rewrite, input bit do_abort);
    logic [SW-1:0] mid = '0;
    int best_it = BOUND, best_u = 0, tot0, tot1, lim;
    logic [NW-1:0] best_n = '0, n;
    bit got = 0;
    for (int k = 0; k < nch; k++) mid = b_perm(mid ^ {{(SW-RW){1'b0}}, b_chunk(base, k)});
    for (int u = 0; u < NU; u++) begin
      n = b_seed(seed, u);
      for (int it = 0; it < BOUND; it++) begin
        if (b_pass(b_perm(b_insert(mid, n)), d)) begin
          if (it < best_it) begin best_it = it; best_u = u; best_n = n; end
          break;
        end
        n = b_step(n);
      end
    end
    write_diff(d);
    for (int u = 0; u < NU; u++) cap_idx[u] = start_cnt[u] + ((u == 0) ? nch : 0);
    job_seed = seed;
    job_start = 1'b1;
    tick();
    job_start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R9 busy after start", {busy, done}, 2'b10);
    if (rewrite) write_diff(0);
    for (int k = 0; k < nch; k++) begin
      msg_valid = 1'b1;
      msg_chunk = b_chunk(base, k);
      msg_last = (k == nch - 1);
      while (msg_ready !== 1'b1) tick();
      tick();
      msg_valid = 1'b0;
      msg_last = 1'b0;
    end
    lim = (best_it < BOUND && !do_abort) ? (best_it + 4) * (LAT + 4) + 100 : 300;
    for (int t = 0; t < lim && !got; t++) begin
      tick();
      if (wr_valid === 1'b1) got = 1;
    end
    if (best_it < BOUND && !do_abort) begin
      chk(got, "R5 result appears", got, 1);
      chk(wr_unit === UW'(best_u), "R5 lowest winning unit", wr_unit, best_u);
      chk(wr_nonce === best_n, "R1,R4 winning nonce", wr_nonce, best_n);
      for (int u = 0; u < NU; u++)
        chk(cap_din[u] === b_insert(mid, b_seed(seed, u)), "R2,R3 first search state",
            cap_din[u], b_insert(mid, b_seed(seed, u)));
      tot0 = start_cnt[0] + start_cnt[1] + start_cnt[2];
      chk(done === 1'b1 && busy === 1'b0, "R9 done with result", {busy, done}, 2'b01);
      tick();
      chk(irq === 1'b1 && wr_valid === 1'b0, "R7 irq after write", {irq, wr_valid}, 2'b10);
      repeat (8) tick();
      tot1 = start_cnt[0] + start_cnt[1] + start_cnt[2];
      chk(tot1 == tot0, "R6 no starts after hit", tot1, tot0);
    end else begin
      tot0 = wr_cnt + irq_cnt;
      chk(!got && busy === 1'b1, "R10 still searching", {got, busy}, 2'b01);
      job_abort = 1'b1;
      tick();
      job_abort = 1'b0;
      chk(busy === 1'b0 && done === 1'b0, "R10 idle after abort", {busy, done}, 2'b00);
      repeat (20) tick();
      chk(wr_cnt + irq_cnt == tot0, "R10 no write or irq", wr_cnt + irq_cnt, tot0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk(busy === 0 && done === 0 && wr_valid === 0 && irq === 0, "R9 reset flags",
        {busy, done, wr_valid, irq}, 0);
    chk(msg_ready === 1'b0 && perm_start === '0, "R2,R9 reset ready and starts",
        {msg_ready, perm_start}, 0);

    for (int v = 0; v < 6; v++)
      run_job(VECS[v][42:31], int'(VECS[v][30:26]), int'(VECS[v][25:24]) + 1,
              VECS[v][23:0], 1'b0, 1'b0);

    // R5 tie: difficulty 0 passes everywhere at once, unit 0 must win.
    run_job(12'h2B7, 0, 1, 24'h123456, 1'b0, 1'b0);
    // R8: difficulty rewritten to 0 mid-job must not change the outcome.
    run_job(12'h6D1, 4, 2, 24'h0A0B0C, 1'b1, 1'b0);
    // R10: impossible difficulty, then abort; a following job still works.
    run_job(12'h155, 14, 1, 24'h777777, 1'b0, 1'b1);
    run_job(12'hC3A, 2, 1, 24'h000111, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule